// File: doc/BRIEF.md
# Per-Core Tick Interval Timer Bank

This block holds a bank of identical local timers, one for each processor core. Each timer has its own 256-byte register window and its own interrupt line. Inside a timer, a prescale counter divides the input clock into ticks. Those ticks step a 31-bit interrupt down-counter. When the down-counter expires it raises a pending flag. In auto-repeat mode the timer then reloads the down-counter from a buffer and keeps running. In single-shot mode it disarms itself after the first expiry.

Software programs a timer through a simple write/read register port. A write to the interrupt count buffer only loads the live counter when bit 31 of the written data is set, so the next period can be staged without disturbing the current one. Every write to the tick buffer, the interrupt buffer or the control register sets a per-register acknowledge flag. Software polls that flag and then clears it by writing 1 to it. The pending flag is cleared the same way. The number of timers is a parameter.

Top module: `tick_timer_bank`

## Requirements
- R1: After reset every register of every timer reads 0 and all `irq` bits are low.
- R2: Timer n answers in the window starting at byte address 0x300 + 0x100*n, using these offsets: tick reload 0x00, interrupt count buffer 0x08, control 0x20, pending 0x30, enable 0x34, write acknowledge 0x40. Reads of any other offset, of a window below 0x300 or of a window at or above 0x300 + 0x100*NUM_CORES return 0.
- R3: While control bit 0 (prescaler run) is 1, the prescaler gives one tick every (tick reload + 1) clock cycles. Clearing bit 0 stops the ticks and resets the prescale count.
- R4: A write to offset 0x08 stores data bits 30:0 in the buffer, which reads back with bit 31 as 0. Only when data bit 31 is 1 is the value also loaded into the live down-counter.
- R5: With control bits 0 and 1 set, the down-counter steps once per tick. A tick that finds it at zero is an expiry, so a loaded value N expires after N+1 ticks, that is (N+1)*(reload+1) cycles after the control write. With control bit 2 (auto-repeat) set, every expiry reloads from the buffer and the control bits stay set, so interrupts repeat every (buffer+1)*(reload+1) cycles.
- R6: With control bit 2 clear, an expiry clears control bit 1, and no further interrupt follows.
- R7: Each expiry sets pending bit 0 at offset 0x30. Writing 1 to that bit clears it; writing 0 has no effect.
- R8: `irq[n]` is high exactly when timer n's pending bit and its enable bit 0 at offset 0x34 are both 1.
- R9: Write-acknowledge bits 0, 1 and 3 at offset 0x40 are set by writes to offsets 0x00, 0x08 and 0x20 respectively. Each bit clears when 1 is written to it; writing 0 leaves it unchanged.
- R10: Timers are independent: activity in one window never changes another timer's registers or interrupt line.
- R11: Control reads back bits 2:0 as written, with all upper bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the timers and the register port |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | ADDR_W | Byte address for the write and for the combinational read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`; 0 when nothing is mapped there |
| irq | output | NUM_CORES | Interrupt line of each timer |

## Verification
A corrupted prescale or down-counter value shows up directly as a shifted interrupt arrival. The bench measures the exact cycle of the first `irq` edge for every pairing of small reload and buffer values, so an error of a single cycle is caught on the first period. A failed auto-repeat reload or a failed single-shot disarm shows up within one further period: either as a wrong gap between consecutive interrupts or as an interrupt that should not appear. A lost or stuck acknowledge or pending bit is visible on the next read of its register.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
   localparam int WIN_SHIFT = 8;
   localparam int FIRST_WIN = 3;
   localparam logic [7:0] OFS_TICK = 8'h00;
   localparam logic [7:0] OFS_ICNT = 8'h08;
   localparam logic [7:0] OFS_CTRL = 8'h20;
   localparam logic [7:0] OFS_PEND = 8'h30;
   localparam logic [7:0] OFS_IEN  = 8'h34;
   localparam logic [7:0] OFS_WACK = 8'h40;
   localparam int CTL_RUN   = 0;
   localparam int CTL_ARM   = 1;
   localparam int CTL_RPT   = 2;
   localparam int LOAD_BIT  = 31;
   localparam int ACK_TICK  = 0;
   localparam int ACK_ICNT  = 1;
   localparam int ACK_CTRL  = 3;
endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
   parameter int TICK_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              restart,
   input  logic [TICK_W-1:0] reload,
   output logic              tick
);
   logic [TICK_W-1:0] pcnt;

   assign tick = run && !restart && (pcnt == reload);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                pcnt <= '0;
      else if (!run || restart)  pcnt <= '0;
      else if (pcnt == reload)   pcnt <= '0;
      else                       pcnt <= pcnt + 1'b1;
   end

   // R3: with a nonzero reload, ticks never come back to back
   a_r3_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && reload != '0) |=> (!tick || reload != $past(reload)));
endmodule

// File: rtl/intr_downcounter.sv
module intr_downcounter #(
   parameter int CNT_W = 31
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] reload_val,
   output logic             expire
);
   logic [CNT_W-1:0] cnt;

   assign expire = run && tick && !load && (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (load)         cnt <= load_val;
      else if (run && tick)  cnt <= (cnt == '0) ? reload_val : cnt - 1'b1;
   end

   // R5: each tick removes exactly one from a nonzero count
   a_r5_step_down: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick && !load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
   // R5: an expiry refills the count from the buffer
   a_r5_refill: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick && !load && cnt == '0) |=> (cnt == $past(reload_val)));
endmodule

// File: rtl/tick_timer_slice.sv
module tick_timer_slice
   import tick_timer_pkg::*;
#(
   parameter int TICK_W = 32,
   parameter int CNT_W  = 31
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        sel,
   input  logic        wr,
   input  logic [7:0]  ofs,
   input  logic [31:0] wdata,
   output logic [31:0] rdata,
   output logic        irq
);
   logic [TICK_W-1:0] tick_rld;
   logic [CNT_W-1:0]  icnt_buf;
   logic [2:0]        ctrl;
   logic              pend, ien;
   logic [3:0]        wack;
   logic              tick, expire;

   logic w_tick, w_icnt, w_ctrl, w_pend, w_ien, w_wack;
   assign w_tick = sel && wr && ofs == OFS_TICK;
   assign w_icnt = sel && wr && ofs == OFS_ICNT;
   assign w_ctrl = sel && wr && ofs == OFS_CTRL;
   assign w_pend = sel && wr && ofs == OFS_PEND;
   assign w_ien  = sel && wr && ofs == OFS_IEN;
   assign w_wack = sel && wr && ofs == OFS_WACK;

   tick_prescaler #(.TICK_W(TICK_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .run(ctrl[CTL_RUN]), .restart(w_tick),
      .reload(tick_rld), .tick(tick));

   intr_downcounter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .run(ctrl[CTL_ARM]), .tick(tick),
      .load(w_icnt && wdata[LOAD_BIT]), .load_val(wdata[CNT_W-1:0]),
      .reload_val(icnt_buf), .expire(expire));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tick_rld <= '0;
         icnt_buf <= '0;
         ctrl     <= '0;
         pend     <= 1'b0;
         ien      <= 1'b0;
      end else begin
         if (w_tick) tick_rld <= wdata[TICK_W-1:0];
         if (w_icnt) icnt_buf <= wdata[CNT_W-1:0];
         if (w_ctrl)                       ctrl <= wdata[2:0];
         else if (expire && !ctrl[CTL_RPT]) ctrl[CTL_ARM] <= 1'b0;
         if (expire)                       pend <= 1'b1;
         else if (w_pend && wdata[0])      pend <= 1'b0;
         if (w_ien) ien <= wdata[0];
      end
   end

   // acknowledge flags: one per acknowledged register, set on write, cleared by writing 1
   localparam int ACK_BITS [3] = '{ACK_TICK, ACK_ICNT, ACK_CTRL};
   logic [2:0] ack_set;
   assign ack_set = {w_ctrl, w_icnt, w_tick};
   assign wack[2] = 1'b0;
   for (genvar k = 0; k < 3; k++) begin : g_ack
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                             wack[ACK_BITS[k]] <= 1'b0;
         else if (ack_set[k])                    wack[ACK_BITS[k]] <= 1'b1;
         else if (w_wack && wdata[ACK_BITS[k]])  wack[ACK_BITS[k]] <= 1'b0;
      end
   end

   always_comb begin
      rdata = '0;
      if (sel) begin
         case (ofs)
            OFS_TICK: rdata = 32'(tick_rld);
            OFS_ICNT: rdata = 32'(icnt_buf);
            OFS_CTRL: rdata = 32'(ctrl);
            OFS_PEND: rdata = 32'(pend);
            OFS_IEN:  rdata = 32'(ien);
            OFS_WACK: rdata = 32'(wack);
            default:  rdata = '0;
         endcase
      end
   end

   assign irq = pend && ien;

   // R6: single-shot expiry disarms the interrupt counter
   a_r6_oneshot_disarm: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && !ctrl[CTL_RPT] && !w_ctrl) |=> !ctrl[CTL_ARM]);
   // R5: auto-repeat expiry leaves the counter armed
   a_r5_repeat_armed: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && ctrl[CTL_RPT] && !w_ctrl) |=> ctrl[CTL_ARM]);
   // R7: pending only rises after an expiry
   a_r7_pend_source: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend) |-> $past(expire));
   // R9: tick acknowledge only rises after a tick reload write
   a_r9_ack_source: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wack[ACK_TICK]) |-> $past(w_tick));
endmodule

// File: rtl/tick_timer_bank.sv
module tick_timer_bank
   import tick_timer_pkg::*;
#(
   parameter int NUM_CORES = 4,
   parameter int ADDR_W    = 12,
   parameter int TICK_W    = 32,
   parameter int CNT_W     = 31
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_wr,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [31:0]          bus_wdata,
   output logic [31:0]          bus_rdata,
   output logic [NUM_CORES-1:0] irq
);
   localparam int WIN_W    = ADDR_W - WIN_SHIFT;
   localparam int WIN_SLOT = 1 << WIN_W;

   if (NUM_CORES < 1 || FIRST_WIN + NUM_CORES > WIN_SLOT) begin : g_bad_cores
      $error("tick_timer_bank: NUM_CORES does not fit the address space");
   end
   if (CNT_W < 1 || CNT_W > LOAD_BIT) begin : g_bad_cnt
      $error("tick_timer_bank: CNT_W must be 1..31");
   end
   if (TICK_W < 1 || TICK_W > 32) begin : g_bad_tick
      $error("tick_timer_bank: TICK_W must be 1..32");
   end

   logic [WIN_W-1:0]    win;
   logic [31:0]         rd_part [NUM_CORES];
   logic [NUM_CORES-1:0] sel;
   assign win = bus_addr[ADDR_W-1:WIN_SHIFT];

   for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
      assign sel[i] = (win == WIN_W'(FIRST_WIN + i));
      tick_timer_slice #(.TICK_W(TICK_W), .CNT_W(CNT_W)) u_slice (
         .clk(clk), .rst_n(rst_n), .sel(sel[i]), .wr(bus_wr),
         .ofs(bus_addr[WIN_SHIFT-1:0]), .wdata(bus_wdata),
         .rdata(rd_part[i]), .irq(irq[i]));
   end

   always_comb begin
      bus_rdata = '0;
      for (int i = 0; i < NUM_CORES; i++) bus_rdata = bus_rdata | rd_part[i];
   end

   // R2: no more than one window answers at a time
   a_r2_one_window: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel));
endmodule

// File: tb/sim_tick_timer_bank.sv
module sim_tick_timer_bank;
   localparam int NC = 2;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [NC-1:0] irq;
   int runs = 0, fails = 0, cyc = 0;
   bit done = 0;

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   tick_timer_bank #(.NUM_CORES(NC), .ADDR_W(12), .TICK_W(8), .CNT_W(31)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      runs++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   function automatic logic [11:0] adr(input int core, input int ofs);
      return 12'(32'h300 + 32'h100 * core + ofs);
   endfunction

   // returns the cycle stamp of the first edge after which irq[core] is high, -1 on timeout
   task automatic wait_irq(input int core, output int t);
      t = -1;
      for (int k = 0; k < 1000; k++) begin
         @(posedge clk); #1;
         if (irq[core]) begin t = cyc; break; end
      end
   endtask

   initial begin
      #(10 * 200000);
      if (!done) begin
         runs++; fails++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", runs, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      int t0, t1, t2;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      foreach (u0.irq[i]) ;
      for (int c = 0; c < NC; c++) begin
         rd(adr(c, 'h00), d); check("R1 tick reload", d, 0);
         rd(adr(c, 'h08), d); check("R1 icnt buffer", d, 0);
         rd(adr(c, 'h20), d); check("R1 ctrl", d, 0);
         rd(adr(c, 'h30), d); check("R1 pending", d, 0);
         rd(adr(c, 'h40), d); check("R1 wack", d, 0);
      end
      check("R1 irq", 32'(irq), 0);

      // R9 acknowledge flags
      wr(adr(0, 'h00), 32'h5);  rd(adr(0, 'h40), d); check("R9 ack tick", d, 32'h1);
      wr(adr(0, 'h08), 32'h7);  rd(adr(0, 'h40), d); check("R9 ack icnt", d, 32'h3);
      wr(adr(0, 'h20), 32'h0);  rd(adr(0, 'h40), d); check("R9 ack ctrl", d, 32'hB);
      wr(adr(0, 'h40), 32'h2);  rd(adr(0, 'h40), d); check("R9 w1c icnt ack", d, 32'h9);
      wr(adr(0, 'h40), 32'h0);  rd(adr(0, 'h40), d); check("R9 write 0 keeps", d, 32'h9);
      wr(adr(0, 'h40), 32'hB);  rd(adr(0, 'h40), d); check("R9 clear all", d, 32'h0);
      rd(adr(1, 'h40), d); check("R10 other ack untouched", d, 0);

      // R11 control readback and R2 decode
      wr(adr(1, 'h20), 32'hFFFF_FFF0 | 32'h4); rd(adr(1, 'h20), d); check("R11 ctrl bits", d, 32'h4);
      wr(adr(1, 'h20), 32'h0);
      rd(12'h510, d); check("R2 out of range window", d, 0);
      wr(12'h500, 32'hFF); rd(12'h500, d); check("R2 out of range write", d, 0);
      rd(12'h200, d); check("R2 below base", d, 0);
      rd(adr(0, 'h10), d); check("R2 unmapped offset", d, 0);
      rd(adr(0, 'h00), d); check("R2 window 0 tick", d, 32'h5);

      // R3 R5 R6 one-shot arrival sweep
      for (int r = 0; r < 4; r++) begin
         for (int n = 0; n < 4; n++) begin
            wr(adr(0, 'h20), 0);
            wr(adr(0, 'h30), 1);
            wr(adr(0, 'h00), r);
            wr(adr(0, 'h08), 32'h8000_0000 | n);
            wr(adr(0, 'h34), 1);
            wr(adr(0, 'h20), 32'h3);
            t0 = cyc;
            wait_irq(0, t1);
            check($sformatf("R3 R5 oneshot arrival r=%0d n=%0d", r, n),
                  32'(t1 - t0), 32'((n + 1) * (r + 1)));
         end
      end
      // R6 disarm, no second interrupt
      rd(adr(0, 'h20), d); check("R6 arm bit cleared", d, 32'h1);
      // R7 pending clear behaviour
      wr(adr(0, 'h30), 0); rd(adr(0, 'h30), d); check("R7 write 0 keeps pending", d, 1);
      // R8 gating
      wr(adr(0, 'h34), 0); #1 check("R8 irq masked", 32'(irq[0]), 0);
      rd(adr(0, 'h30), d); check("R8 pending still set", d, 1);
      wr(adr(0, 'h34), 1); #1 check("R8 irq unmasked", 32'(irq[0]), 1);
      wr(adr(0, 'h30), 1); rd(adr(0, 'h30), d); check("R7 w1c pending", d, 0);
      repeat (40) @(negedge clk);
      check("R6 no second interrupt", 32'(irq[0]), 0);

      // R4 buffer-only write does not load the counter
      wr(adr(0, 'h20), 0);
      wr(adr(0, 'h00), 0);
      wr(adr(0, 'h08), 32'h8000_0005);
      wr(adr(0, 'h08), 32'h0000_0001);
      rd(adr(0, 'h08), d); check("R4 buffer readback", d, 32'h1);
      wr(adr(0, 'h08), 32'h8000_0005);
      rd(adr(0, 'h08), d); check("R4 load bit not stored", d, 32'h5);
      wr(adr(0, 'h08), 32'h0000_0001);
      wr(adr(0, 'h20), 32'h3);
      t0 = cyc; wait_irq(0, t1);
      check("R4 counter kept loaded value", 32'(t1 - t0), 32'd6);
      wr(adr(0, 'h20), 0); wr(adr(0, 'h30), 1);

      // R5 auto-repeat on core 1, R10 independence
      wr(adr(1, 'h00), 2);
      wr(adr(1, 'h08), 32'h8000_0003);
      wr(adr(1, 'h34), 1);
      wr(adr(1, 'h20), 32'h7);
      t0 = cyc; wait_irq(1, t1);
      check("R5 repeat first", 32'(t1 - t0), 32'd12);
      wr(adr(1, 'h30), 1);
      wait_irq(1, t2);
      check("R5 repeat period 1", 32'(t2 - t1), 32'd12);
      wr(adr(1, 'h30), 1);
      wait_irq(1, t1);
      check("R5 repeat period 2", 32'(t1 - t2), 32'd12);
      check("R10 core 0 quiet", 32'(irq[0]), 0);
      rd(adr(1, 'h20), d); check("R5 ctrl stays armed", d, 32'h7);
      rd(adr(0, 'h30), d); check("R10 core 0 pending clear", d, 0);
      wr(adr(1, 'h20), 0); wr(adr(1, 'h30), 1);
      #1 check("R7 core 1 cleared", 32'(irq), 0);

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", runs, fails);
      $finish;
   end
endmodule